// File: doc/BRIEF.md
# Three-Stage Sinc and Half-Band Decimation Filter

This block turns a few-bit signed oversampled stream, one sample per accepted master-clock cycle, into 24-bit two's complement words at a rate lowered by 8, 16 or 32. The ratio is set by the parameter `DECIM`. The first stage is a seventh-order sinc (integrator/comb) decimator whose ratio is `DECIM/4`. It is followed by two identical linear-phase half-band FIR sections, and each of them keeps one output for every two inputs. A final stage scales the result to the 24-bit output range, rounds it, clips it to that range, and holds back the first words whose filter memory still reaches back before a reset.

The stream is qualified by `mod_valid`, and cycles with `mod_valid` low have no effect at all. A synchronous `restart` input clears every stage, just as `rst_n` does, so several filters can be aligned by restarting them together. Each result appears on `word_data` with a one-cycle `word_stb`.

Top module: `sfd_decim`

## Requirements
- R1: After settling, exactly one word is produced for every `DECIM` accepted samples (`DECIM` is 8, 16 or 32), and the first-stage ratio R is `DECIM/4`.
- R2: First-stage output m equals the accepted input x convolved with seven cascaded boxcars of length R, taken at input index m·R+R−1. Indices count from 0 at the first sample after reset or restart, and the input is taken as zero before that.
- R3: Each half-band section uses the symmetric taps (−1, 0, 9, 16, 9, 0, −1). Output p is the sum over j = 0..6 of tap[j]·u[2p+1−j], plus 16, shifted arithmetically right by 5 (rounding half up). Inputs before index 0 count as zero.
- R4: Let W = `IN_W` + 7·log2(R) and S = 24 − W + `GAIN_SH`. When S ≥ 0 the second half-band result is shifted left by S. Otherwise 2^(−S−1) is added and the result is shifted arithmetically right by −S.
- R5: Scaled results above 0x7FFFFF are output as 0x7FFFFF, and results below −0x800000 are output as 0x800000.
- R6: After reset or restart, the first K final words are withheld, where K = floor((25·R − 7)/(4·R)). This gives 5 for R of 2 or 4 and 6 for R of 8.
- R7: A restart pulse clears all filter state and the settling count, and no word is strobed in the cycle after it.
- R8: Cycles with `mod_valid` low do not change any word value or the word count, whatever `mod_data` holds.
- R9: `word_stb` is high for single cycles and never in two consecutive cycles.
- R10: While reset is held, `word_stb` is 0 and `word_data` is 0.
- R11: A constant input x gives settled words equal to x·2^(24−`IN_W`+`GAIN_SH`), clipped as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous filter restart, active high |
| mod_valid | input | 1 | Qualifies `mod_data` in this cycle |
| mod_data | input | IN_W | Signed modulator sample |
| word_stb | output | 1 | One-cycle strobe for a new output word |
| word_data | output | OUT_W | Output word, two's complement |

## Verification
The bench builds two copies side by side from the same stimulus. The first uses `DECIM` = 32 with no extra gain; its 25-bit sinc width is above 24 bits, so the rounding right shift of R4 and the six-word settling of R6 come into play. The second uses `DECIM` = 8 with `GAIN_SH` = 1; its 11-bit sinc width makes the left-shift path active, and full-scale input then drives both clipping limits of R5. Constant, stepped and random streams, with and without idle cycles and with restarts between runs, are compared word by word against an arithmetic model written straight from R2 to R4.

// File: rtl/sfd_pkg.sv
// Shared constants for the sinc/half-band decimator.
// Assumes: half-band taps sum to 2^HB_NORM so a constant passes with unit gain.
package sfd_pkg;
    localparam int CIC_ORDER = 7;
    localparam int HB_LEN    = 7;
    localparam int HB_NORM   = 5;

    // Tap value of the symmetric half-band kernel at position idx.
    function automatic int hb_tap(input int idx);
        case (idx)
            0, 6:    return -1;
            2, 4:    return 9;
            3:       return 16;
            default: return 0;
        endcase
    endfunction

    // Number of leading output words whose span reaches before a restart.
    function automatic int settle_words(input int r1);
        return (25 * r1 - 7) / (4 * r1);
    endfunction
endpackage

// File: rtl/sfd_cic.sv
// Seventh-order integrator/comb decimator, ratio RATIO (a power of two).
// Integrators update combinationally in one chain per accepted sample, so the
// decimation phase matches the plain convolution definition exactly.
// Assumes: ACC_W >= IN_W + ORDER*log2(RATIO); wraparound arithmetic is intended.
module sfd_cic #(
    parameter int IN_W  = 4,
    parameter int RATIO = 8,
    parameter int ORDER = 7,
    parameter int ACC_W = IN_W + ORDER * $clog2(RATIO)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_stb,
    output logic signed [ACC_W-1:0] out_data
);
    localparam int PH_W = $clog2(RATIO);

    logic                    clr;
    logic signed [ACC_W-1:0] x_ext;
    logic [PH_W-1:0]         ph_q;
    logic                    dump;

    assign clr   = !rst_n || restart;
    assign x_ext = ACC_W'(in_data);
    assign dump  = in_valid && (ph_q == PH_W'(RATIO - 1));

    // Integrator cascade: each stage adds the freshly updated stage before it.
    for (genvar j = 0; j < ORDER; j++) begin : g_int
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] acc_d;
        if (j == 0) begin : g_first
            assign acc_d = acc_q + x_ext;
        end else begin : g_next
            assign acc_d = acc_q + g_int[j-1].acc_d;
        end
        // Hold the running sum, advancing only on accepted samples.
        always_ff @(posedge clk) begin
            if (clr)           acc_q <= '0;
            else if (in_valid) acc_q <= acc_d;
        end
    end

    // Count accepted samples within one decimation group.
    always_ff @(posedge clk) begin
        if (clr)           ph_q <= '0;
        else if (in_valid) ph_q <= ph_q + 1'b1;
    end

    // Comb cascade at the decimated rate.
    for (genvar j = 0; j < ORDER; j++) begin : g_cmb
        logic signed [ACC_W-1:0] src;
        logic signed [ACC_W-1:0] hist_q;
        logic signed [ACC_W-1:0] diff;
        if (j == 0) begin : g_first
            assign src = g_int[ORDER-1].acc_d;
        end else begin : g_next
            assign src = g_cmb[j-1].diff;
        end
        assign diff = src - hist_q;
        // Remember the previous decimated value of this comb's input.
        always_ff @(posedge clk) begin
            if (clr)       hist_q <= '0;
            else if (dump) hist_q <= src;
        end
    end

    // Register the decimated result and its strobe.
    always_ff @(posedge clk) begin
        if (clr) begin
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= dump;
            if (dump) out_data <= g_cmb[ORDER-1].diff;
        end
    end

    // R1: a decimated result only follows an accepted sample.
    a_r1_cic_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(in_valid));
    // R9: the first stage never strobes twice in a row.
    a_r9_cic_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> !out_stb);
    // R8: an idle cycle leaves the group position untouched.
    a_r8_cic_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !restart) |=> $stable(ph_q));
endmodule

// File: rtl/sfd_hb.sv
// Decimate-by-two half-band FIR with fixed symmetric taps from sfd_pkg.
// Computes only on odd-indexed inputs; symmetric pairs are pre-added.
// Assumes: OUT_W is wide enough for the worst-case gain of the taps (36/32).
module sfd_hb #(
    parameter int IN_W  = 25,
    parameter int OUT_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart,
    input  logic                    in_stb,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_stb,
    output logic signed [OUT_W-1:0] out_data
);
    import sfd_pkg::*;

    localparam int AW   = IN_W + 7;
    localparam int HALF = HB_LEN / 2;
    localparam logic signed [AW-1:0] OUT_HI = AW'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [AW-1:0] OUT_LO = ~OUT_HI;

    logic                    clr;
    logic signed [IN_W-1:0]  dly_q [HB_LEN-1];
    logic signed [IN_W-1:0]  win   [HB_LEN];
    logic signed [AW-1:0]    term  [HALF+1];
    logic signed [AW-1:0]    acc;
    logic signed [AW-1:0]    rnd;
    logic                    odd_q;
    logic                    fire;

    assign clr  = !rst_n || restart;
    assign fire = in_stb && odd_q;

    // Window: newest sample first, then the delay line.
    assign win[0] = in_data;
    for (genvar j = 1; j < HB_LEN; j++) begin : g_win
        assign win[j] = dly_q[j-1];
    end

    // Symmetric pair products; zero taps produce no logic.
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        localparam logic signed [AW-1:0] CF = AW'(hb_tap(p));
        if (hb_tap(p) != 0) begin : g_nz
            assign term[p] = (AW'(win[p]) + AW'(win[HB_LEN-1-p])) * CF;
        end else begin : g_z
            assign term[p] = '0;
        end
    end
    localparam logic signed [AW-1:0] CF_MID = AW'(hb_tap(HALF));
    assign term[HALF] = AW'(win[HALF]) * CF_MID;

    // Sum the pair products.
    always_comb begin
        acc = '0;
        for (int k = 0; k <= HALF; k++) acc = acc + term[k];
    end

    assign rnd = (acc + AW'(1 << (HB_NORM - 1))) >>> HB_NORM;

    // Shift the delay line on every input.
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < HB_LEN - 1; i++) dly_q[i] <= '0;
        end else if (in_stb) begin
            dly_q[0] <= in_data;
            for (int i = 1; i < HB_LEN - 1; i++) dly_q[i] <= dly_q[i-1];
        end
    end

    // Track whether the next input has an odd index.
    always_ff @(posedge clk) begin
        if (clr)         odd_q <= 1'b0;
        else if (in_stb) odd_q <= !odd_q;
    end

    // Register one output per two inputs.
    always_ff @(posedge clk) begin
        if (clr) begin
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= fire;
            if (fire) out_data <= OUT_W'(rnd);
        end
    end

    // R3: the rounded sum always fits the output width.
    a_r3_hb_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (rnd <= OUT_HI && rnd >= OUT_LO));
    // R3: each output follows an input by exactly one cycle.
    a_r3_hb_after_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(in_stb));
    // R9: outputs are never back to back.
    a_r9_hb_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> !out_stb);
endmodule

// File: rtl/sfd_out.sv
// Output stage: aligns the filtered value to OUT_W bits (shift left, or
// round-half-up shift right), clips to the two's complement range and holds
// back the first SETTLE words after a reset or restart.
// Assumes: SRC_W is the first-stage width that sets the unit scale of in_data.
module sfd_out #(
    parameter int IN_W    = 26,
    parameter int SRC_W   = 25,
    parameter int OUT_W   = 24,
    parameter int GAIN_SH = 0,
    parameter int SETTLE  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic                   in_stb,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   word_stb,
    output logic [OUT_W-1:0]       word_data
);
    localparam int SH = OUT_W - SRC_W + GAIN_SH;
    localparam int XW = (SH > 0) ? IN_W + SH + 1 : IN_W + 1;
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic signed [XW-1:0]    HI   = XW'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [XW-1:0]    LO   = ~HI;
    localparam logic signed [OUT_W-1:0] HI_O = OUT_W'((longint'(1) <<< (OUT_W - 1)) - 1);
    localparam logic signed [OUT_W-1:0] LO_O = ~HI_O;

    logic                    clr;
    logic signed [XW-1:0]    ext;
    logic signed [XW-1:0]    scaled;
    logic signed [OUT_W-1:0] sat_v;
    logic [CW-1:0]           seen_q;
    logic                    ready;

    assign clr   = !rst_n || restart;
    assign ext   = XW'(in_data);
    assign ready = (seen_q == CW'(SETTLE));

    if (SH >= 0) begin : g_up
        assign scaled = ext <<< SH;
    end else begin : g_dn
        assign scaled = (ext + XW'(longint'(1) <<< (-SH - 1))) >>> (-SH);
    end

    assign sat_v = (scaled > HI) ? HI_O :
                   (scaled < LO) ? LO_O : scaled[OUT_W-1:0];

    // Count words that still carry pre-restart history.
    always_ff @(posedge clk) begin
        if (clr)                  seen_q <= '0;
        else if (in_stb && !ready) seen_q <= seen_q + 1'b1;
    end

    // Publish settled words with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (clr) begin
            word_stb  <= 1'b0;
            word_data <= '0;
        end else begin
            word_stb <= in_stb && ready;
            if (in_stb && ready) word_data <= sat_v;
        end
    end

    // R6: nothing leaves while the settling count is still running.
    a_r6_withheld: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !restart) |=> !word_stb);
endmodule

// File: rtl/sfd_decim.sv
// Top: sinc decimator by DECIM/4, then two half-band decimate-by-two stages,
// then alignment, clipping and settling suppression.
// Assumes: DECIM is 8, 16 or 32; restart and rst_n are both synchronous.
module sfd_decim #(
    parameter int DECIM   = 32,
    parameter int IN_W    = 4,
    parameter int OUT_W   = 24,
    parameter int GAIN_SH = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic                   mod_valid,
    input  logic signed [IN_W-1:0] mod_data,
    output logic                   word_stb,
    output logic [OUT_W-1:0]       word_data
);
    import sfd_pkg::*;

    localparam int R1     = DECIM / 4;
    localparam int CIC_W  = IN_W + CIC_ORDER * $clog2(R1);
    localparam int HB_W   = CIC_W + 1;
    localparam int SETTLE = settle_words(R1);

    logic                    s1_stb;
    logic signed [CIC_W-1:0] s1_data;
    logic                    s2_stb;
    logic signed [HB_W-1:0]  s2_data;
    logic                    s3_stb;
    logic signed [HB_W-1:0]  s3_data;

    sfd_cic #(.IN_W(IN_W), .RATIO(R1), .ORDER(CIC_ORDER), .ACC_W(CIC_W)) u_cic (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(mod_valid), .in_data(mod_data),
        .out_stb(s1_stb), .out_data(s1_data)
    );

    sfd_hb #(.IN_W(CIC_W), .OUT_W(HB_W)) u_hb1 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_stb(s1_stb), .in_data(s1_data),
        .out_stb(s2_stb), .out_data(s2_data)
    );

    sfd_hb #(.IN_W(HB_W), .OUT_W(HB_W)) u_hb2 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_stb(s2_stb), .in_data(s2_data),
        .out_stb(s3_stb), .out_data(s3_data)
    );

    sfd_out #(.IN_W(HB_W), .SRC_W(CIC_W), .OUT_W(OUT_W),
              .GAIN_SH(GAIN_SH), .SETTLE(SETTLE)) u_out (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_stb(s3_stb), .in_data(s3_data),
        .word_stb(word_stb), .word_data(word_data)
    );

    // R7: a restart silences the output in the following cycle.
    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !word_stb);
    // R9: single-cycle word strobes.
    a_r9_word_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
    // R1: a word is always preceded by a final-stage result.
    a_r1_word_after_stage: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> $past(s3_stb));
endmodule

// File: tb/sfd_decim_tb.sv
`timescale 1ns/1ps
module sfd_decim_tb;
    localparam int IN_W  = 4;
    localparam int OUT_W = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst_n;
    logic                   restart;
    logic                   mod_valid;
    logic signed [IN_W-1:0] mod_data;
    logic                   stb_a, stb_b;
    logic [OUT_W-1:0]       word_a, word_b;

    sfd_decim #(.DECIM(32), .IN_W(IN_W), .OUT_W(OUT_W), .GAIN_SH(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mod_valid(mod_valid),
        .mod_data(mod_data), .word_stb(stb_a), .word_data(word_a)
    );
    sfd_decim #(.DECIM(8), .IN_W(IN_W), .OUT_W(OUT_W), .GAIN_SH(1)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mod_valid(mod_valid),
        .mod_data(mod_data), .word_stb(stb_b), .word_data(word_b)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    int         xs[$];
    longint     exp_a[$];
    longint     exp_b[$];
    longint     hc [2][64];
    int         cnt_a, cnt_b;
    logic [23:0] last_a, last_b;

    // Per-copy settings from R1, R4, R6: first-stage ratio, sinc width, gain, settle.
    function automatic int r1_of(int s);    return (s == 0) ? 8 : 2;  endfunction
    function automatic int w_of(int s);     return (s == 0) ? 25 : 11; endfunction
    function automatic int gain_of(int s);  return (s == 0) ? 0 : 1;  endfunction
    function automatic int settle_of(int s); return (s == 0) ? 6 : 5; endfunction
    function automatic int tap(int j);
        case (j) 0, 6: return -1; 2, 4: return 9; 3: return 16; default: return 0; endcase
    endfunction

    // Coefficient i of seven cascaded boxcars of length r (R2).
    function automatic longint box7(int r, int i);
        longint dp[64];
        longint nx[64];
        for (int t = 0; t < 64; t++) dp[t] = (t == 0) ? 1 : 0;
        for (int st = 0; st < 7; st++) begin
            for (int t = 0; t < 64; t++) begin
                nx[t] = 0;
                for (int u = 0; u < r; u++) if (t - u >= 0) nx[t] += dp[t-u];
            end
            for (int t = 0; t < 64; t++) dp[t] = nx[t];
        end
        return dp[i];
    endfunction

    function automatic longint y1(int s, longint m);
        longint acc = 0;
        longint k0;
        if (m < 0) return 0;
        k0 = m * r1_of(s) + r1_of(s) - 1;
        for (int i = 0; i <= 7 * (r1_of(s) - 1); i++)
            if (k0 - i >= 0) acc += hc[s][i] * longint'(xs[k0-i]);
        return acc;
    endfunction

    function automatic longint hb1(int s, longint p);
        longint acc = 0;
        if (p < 0) return 0;
        for (int j = 0; j < 7; j++) acc += longint'(tap(j)) * y1(s, 2 * p + 1 - j);
        return (acc + 16) >>> 5;
    endfunction

    function automatic longint hb2(int s, longint q);
        longint acc = 0;
        for (int j = 0; j < 7; j++) acc += longint'(tap(j)) * hb1(s, 2 * q + 1 - j);
        return (acc + 16) >>> 5;
    endfunction

    // R4 alignment and R5 clipping.
    function automatic longint final_word(int s, longint q);
        longint v = hb2(s, q);
        int sh = 24 - w_of(s) + gain_of(s);
        if (sh >= 0) v = v <<< sh;
        else         v = (v + (longint'(1) <<< (-sh - 1))) >>> (-sh);
        if (v > 64'sh7FFFFF)  v = 64'sh7FFFFF;
        if (v < -64'sh800000) v = -64'sh800000;
        return v & 64'hFFFFFF;
    endfunction

    task automatic chk(string tag, longint act, longint expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: record a sample, queue any word it completes, then apply it.
    task automatic drive(int x, int gapmax);
        int k;
        xs.push_back(x);
        k = xs.size() - 1;
        for (int s = 0; s < 2; s++) begin
            int d = 4 * r1_of(s);
            if ((k + 1) % d == 0) begin
                int q = (k + 1) / d - 1;
                if (q >= settle_of(s)) begin
                    if (s == 0) exp_a.push_back(final_word(s, q));
                    else        exp_b.push_back(final_word(s, q));
                end
            end
        end
        @(negedge clk);
        mod_valid = 1'b1;
        mod_data  = IN_W'(x);
        if (gapmax > 0) begin
            int g = $urandom_range(gapmax);
            for (int i = 0; i < g; i++) begin
                @(negedge clk);
                mod_valid = 1'b0;
                mod_data  = IN_W'($urandom_range(15));
            end
        end
    endtask

    // Let the pipeline drain, then check all queued words arrived (R1, R6).
    task automatic finish_run(int n, string tag);
        @(negedge clk);
        mod_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk({"R1 words left on u_dut ", tag}, exp_a.size(), 0);
        chk({"R1 words left on u_dut_b ", tag}, exp_b.size(), 0);
        chk({"R6 word count u_dut ", tag}, cnt_a, (n / 32 > 6) ? n / 32 - 6 : 0);
        chk({"R6 word count u_dut_b ", tag}, cnt_b, (n / 8 > 5) ? n / 8 - 5 : 0);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart   = 1'b1;
        mod_valid = 1'b0;
        @(negedge clk);
        chk("R7 no strobe after restart u_dut", stb_a, 0);
        chk("R7 no strobe after restart u_dut_b", stb_b, 0);
        restart = 1'b0;
        xs.delete();
        cnt_a = 0;
        cnt_b = 0;
    endtask

    initial begin
        logic prev_a, prev_b;
        rst_n = 1'b0; restart = 1'b0; mod_valid = 1'b0; mod_data = '0;
        cnt_a = 0; cnt_b = 0; last_a = '0; last_b = '0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 64; i++) hc[s][i] = box7(r1_of(s), i);

        // Monitor: pop the scoreboard on every strobe.
        prev_a = 1'b0; prev_b = 1'b0;
        fork
            forever begin
                @(negedge clk);
                if (rst_n && stb_a) begin
                    cnt_a++;
                    chk("R9 back-to-back strobe u_dut", prev_a, 0);
                    if (exp_a.size() == 0) chk("R1 unexpected word u_dut", 1, 0);
                    else chk("R2/R3/R4 word u_dut", longint'(word_a), exp_a.pop_front());
                    last_a = word_a;
                end
                if (rst_n && stb_b) begin
                    cnt_b++;
                    chk("R9 back-to-back strobe u_dut_b", prev_b, 0);
                    if (exp_b.size() == 0) chk("R1 unexpected word u_dut_b", 1, 0);
                    else chk("R2/R3/R4/R5 word u_dut_b", longint'(word_b), exp_b.pop_front());
                    last_b = word_b;
                end
                prev_a = stb_a;
                prev_b = stb_b;
            end
            begin
                repeat (200000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL R1 watchdog expired");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none

        // R10: reset state.
        repeat (3) @(negedge clk);
        chk("R10 reset strobe u_dut", stb_a, 0);
        chk("R10 reset data u_dut", word_a, 0);
        chk("R10 reset strobe u_dut_b", stb_b, 0);
        chk("R10 reset data u_dut_b", word_b, 0);
        rst_n = 1'b1;

        // Run 1: constant +7, continuous (R11, R5 upper clip on u_dut_b).
        for (int i = 0; i < 384; i++) drive(7, 0);
        finish_run(384, "dc+7");
        chk("R11 constant +7 u_dut", last_a, 24'h700000);
        chk("R5 upper clip u_dut_b", last_b, 24'h7FFFFF);

        // Run 2: constant -8 with idle gaps (R8, R11, R5 lower limit).
        do_restart();
        for (int i = 0; i < 320; i++) drive(-8, 2);
        finish_run(320, "dc-8");
        chk("R11 constant -8 u_dut", last_a, 24'h800000);
        chk("R5 lower clip u_dut_b", last_b, 24'h800000);

        // Run 3: random codes with idle gaps (R2, R3, R4, R8).
        do_restart();
        for (int i = 0; i < 1280; i++) drive(int'($urandom_range(15)) - 8, 1);
        finish_run(1280, "random");

        // Run 4: full-scale steps, continuous (R3 overshoot, R5).
        do_restart();
        for (int i = 0; i < 640; i++) drive(((i / 24) % 2 == 0) ? 7 : -8, 0);
        finish_run(640, "steps");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule